// File: doc/BRIEF.md
# Serial UART with Receiver Wakeup and Noise Flagging

This block is an asynchronous serial transmitter and receiver for a single line pair. Each frame starts with one low start bit, carries its data least significant bit first, and ends with one high stop bit. The line rests high between frames. The transmitter and the receiver have separate enables, so the block can run in half duplex with one direction active or in full duplex with both. A holding register sits in front of the transmit shifter, so software can queue the next character while the current one is still going out.

A modulus divider derives a sampling tick from the system clock. The receiver samples each bit sixteen times per bit period, takes a majority of three samples near the centre of the bit, and flags noise when those samples disagree. Software picks an 8- or 9-bit word. Parity is optional and even or odd. When parity is on, the most significant bit of the word is the parity bit. A wakeup mode discards received characters until one of two conditions occurs: a character whose most significant bit is set, or a full frame time of idle line. This lets the processor ignore traffic meant for other stations.

Software reaches the block through a small register bus with three addresses. Address 0 is control, address 1 is status and address 2 is data. Reads are combinational. A read strobe on the data address takes the received character.

Top module: `serial_wake_uart`

## Requirements
- R1: The transmit line idles high. A frame is one 0 start bit, then the word least significant bit first, then one 1 stop bit. Every bit lasts 16 sample ticks. The start bit appears in the cycle after the holding register moves into the shifter.
- R2: Control bit 13 enables the transmitter and control bit 14 enables the receiver. The two act independently. With bit 13 low, no new frame starts. With bit 14 low, the receive line is ignored and no character or flag is captured.
- R3: Writing address 2 loads the holding register and clears status bit 0 (holding empty) and status bit 1 (transmit complete). Bit 0 sets again when the holding register moves into the shifter. Bit 1 sets when a frame ends with the holding register empty. Both are 1 after reset.
- R4: With control bit 15 at 0 the word is 8 bits. With control bit 15 at 1 it is 9 bits. Received words appear right-aligned at address 2.
- R5: Control bit 16 enables parity and control bit 17 selects odd (1) or even (0). On transmit, the word's most significant bit is replaced by the parity of the lower bits. On receive, status bit 7 is set when the count of ones in the whole word does not match the selected parity.
- R6: The receiver takes samples 7, 8 and 9 of each bit and decides the bit by majority. If any bit of a frame has samples that disagree, status bit 5 (noise) is latched with that character, and the data is still received correctly.
- R7: Control bit 18 is the wakeup bit. While it is set, received characters are discarded and leave status bit 2 alone. Control bit 19 picks the wake condition: 1 means a character whose most significant bit is set, and that character is kept; 0 means the line stays high for a frame time after a character. Bit 18 clears itself when the condition occurs.
- R8: Control bits 12:0 hold the divisor N. A sample tick occurs every 2N clocks, so the baud rate is the clock divided by 32N. N = 0 stops all transmit and receive timing.
- R9: After a start bit has been seen, status bit 3 (idle) sets once the receive line has stayed high for about one frame time.
- R10: If a character completes while status bit 2 (receive full) is still set, status bit 4 (overrun) sets. The new character is dropped and the stored data stays unchanged.
- R11: If the stop bit samples low by majority, status bit 6 (framing error) is latched with the character.
- R12: A read strobe at address 2 clears status bits 2 through 7. irq_tx is control bit 21 AND holding empty. irq_rx is control bit 20 AND receive full AND wakeup bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect at data address only) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit holding register empty interrupt |
| irq_rx | output | 1 | Receive data full interrupt |

## Verification
The transmit line and the two transmit status bits are compared every cycle against a behavioural model. The model is driven with back-to-back writes, 8- and 9-bit words, both parity senses, a disabled transmitter and a zero divisor, which separates errors in bit order, parity insertion, buffering and gating. Receive frames are fed clean, with a one-sample glitch, with a low stop bit, with wrong parity and back to back without a read. These patterns separate the noise, framing, parity and overrun paths from one another. Both wake conditions are run with a discarded character first, so a wake that fires too early shows up as extra received data.

// File: rtl/serial_wake_uart.sv
module serial_wake_uart #(
  parameter int DIV_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_tx,
  output logic        irq_rx
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] div_n;
  logic te, re, nine, pen, podd, wake, wake_adr, rx_ie, tx_ie;

  wire wr_ctrl = wr_en && addr == 2'd0;
  wire wr_data = wr_en && addr == 2'd2;
  wire rd_data = rd_en && addr == 2'd2;
  wire [3:0] wlen = nine ? 4'd9 : 4'd8;

  // sample tick generator
  logic [CW-1:0] div_cnt;
  wire [CW-1:0] div_top = {div_n, 1'b0} - CW'(1);
  wire tick = (div_n != '0) && (div_cnt >= div_top);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else if (div_n == '0 || tick) div_cnt <= '0;
    else div_cnt <= div_cnt + CW'(1);

  // transmitter
  logic [8:0]  hold;
  logic        hold_full, tx_busy, tc;
  logic [10:0] tx_sh;
  logic [3:0]  tx_left, tx_sub;
  logic [8:0]  tx_word;

  wire load    = !tx_busy && hold_full && te;
  wire tx_last = tx_busy && tick && tx_sub == 4'd15 && tx_left == 4'd1;
  wire tx_par  = ^(hold & (nine ? 9'h0FF : 9'h07F)) ^ podd;

  always_comb begin
    tx_word = hold;
    if (pen) begin
      if (nine) tx_word[8] = tx_par;
      else      tx_word[7] = tx_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_sub <= '0;
    end else if (load) begin
      tx_busy <= 1'b1;
      tx_sh   <= nine ? {1'b1, tx_word, 1'b0} : {2'b11, tx_word[7:0], 1'b0};
      tx_left <= wlen + 4'd2;
      tx_sub  <= '0;
    end else if (tx_busy && tick) begin
      tx_sub <= tx_sub + 4'd1;
      if (tx_sub == 4'd15) begin
        if (tx_left == 4'd1) tx_busy <= 1'b0;
        else begin
          tx_sh   <= {1'b1, tx_sh[10:1]};
          tx_left <= tx_left - 4'd1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; tc <= 1'b1;
    end else begin
      if (wr_data) hold <= wdata[8:0];
      hold_full <= wr_data ? 1'b1 : (load ? 1'b0 : hold_full);
      if (wr_data) tc <= 1'b0;
      else if (tx_last && !hold_full) tc <= 1'b1;
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  logic       rx_busy, s7, s8, rx_noise, armed;
  logic [3:0] rx_ph, rx_idx;
  logic [8:0] rx_sh, rx_data;
  logic       rdrf, ovr, nf, fe, pe, idle_f;
  logic [7:0] idle_cnt;

  wire maj      = (s7 & s8) | (s7 & rxd) | (s8 & rxd);
  wire disagree = !((s7 == s8) && (s8 == rxd));
  wire rx_eval  = rx_busy && tick && rx_ph == 4'd9;
  wire rx_last  = rx_idx == wlen + 4'd1;
  wire rx_done  = rx_eval && rx_last;
  wire [8:0] word = nine ? rx_sh : {1'b0, rx_sh[8:1]};
  wire take     = rx_done && (!wake || (wake_adr && rx_sh[8]));
  wire pe_now   = pen && (^word ^ podd);
  wire start    = re && !rx_busy && tick && !rxd;
  wire [7:0] idle_lim = nine ? 8'd175 : 8'd159;
  wire idle_hit = re && !rx_busy && tick && rxd && armed && idle_cnt == idle_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_ph <= '0; rx_idx <= '0; s7 <= 1'b1; s8 <= 1'b1;
      rx_noise <= 1'b0; rx_sh <= '0;
    end else if (!re) rx_busy <= 1'b0;
    else if (start) begin
      rx_busy <= 1'b1; rx_ph <= 4'd1; rx_idx <= '0; rx_noise <= 1'b0; rx_sh <= '0;
    end else if (rx_busy && tick) begin
      rx_ph <= rx_ph + 4'd1;
      if (rx_ph == 4'd7) s7 <= rxd;
      if (rx_ph == 4'd8) s8 <= rxd;
      if (rx_ph == 4'd9) begin
        if (disagree) rx_noise <= 1'b1;
        rx_idx <= rx_idx + 4'd1;
        if ((rx_idx == 4'd0 && maj) || rx_last) rx_busy <= 1'b0;
        else if (rx_idx != 4'd0) rx_sh <= {maj, rx_sh[8:1]};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_cnt <= '0; armed <= 1'b0;
    end else begin
      if (start) armed <= 1'b1;
      else if (idle_hit) armed <= 1'b0;
      if (rx_busy || !rxd) idle_cnt <= '0;
      else if (tick && idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdrf <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0; pe <= 1'b0; idle_f <= 1'b0;
      rx_data <= '0;
    end else begin
      if (rd_data) begin
        rdrf <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0; pe <= 1'b0; idle_f <= 1'b0;
      end
      if (idle_hit) idle_f <= 1'b1;
      if (take) begin
        if (rdrf && !rd_data) ovr <= 1'b1;
        else begin
          rdrf <= 1'b1; rx_data <= word;
          nf <= rx_noise | disagree; fe <= !maj; pe <= pe_now;
        end
      end
    end

  // control register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_n <= '0; te <= 1'b0; re <= 1'b0; nine <= 1'b0; pen <= 1'b0; podd <= 1'b0;
      wake <= 1'b0; wake_adr <= 1'b0; rx_ie <= 1'b0; tx_ie <= 1'b0;
    end else if (wr_ctrl) begin
      div_n <= wdata[DIV_W-1:0];
      {tx_ie, rx_ie, wake_adr, wake, podd, pen, nine, re, te} <= wdata[21:13];
    end else if (wake && ((take && wake_adr) || (idle_hit && !wake_adr)))
      wake <= 1'b0;

  always_comb
    case (addr)
      2'd0:    rdata = {10'd0, tx_ie, rx_ie, wake_adr, wake, podd, pen, nine, re, te, 13'(div_n)};
      2'd1:    rdata = {24'd0, pe, fe, nf, ovr, idle_f, rdrf, tc, !hold_full};
      2'd2:    rdata = {23'd0, rx_data};
      default: rdata = '0;
    endcase

  assign irq_tx = tx_ie && !hold_full;
  assign irq_rx = rx_ie && rdrf && !wake;

  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  p_te_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !tx_busy && !wr_ctrl) |=> !tx_busy);
  p_re_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!re && !wr_ctrl) |=> !rx_busy);
  p_hold_freed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && !$past(wr_data)) |-> !hold_full);
  p_wake_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wake_adr && !wr_ctrl) |=> !$rose(rdrf));
  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_n == '0 && !wr_ctrl && !load) |=> ($stable(tx_sub) && $stable(rx_ph)));
  p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rdrf && !rd_data) |=> ($stable(rx_data) && ovr));
endmodule

// File: tb/serial_wake_uart_tb.sv
module serial_wake_uart_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  addr = 2'd1;
  logic        wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         txd, irq_tx, irq_rx;

  int n_tests = 0, n_fail = 0;

  localparam int TE = 1 << 13, RE = 1 << 14, NINE = 1 << 15, PEN = 1 << 16, PODD = 1 << 17;
  localparam int WAKE = 1 << 18, WADR = 1 << 19, RXIE = 1 << 20, TXIE = 1 << 21;

  serial_wake_uart u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // behavioural transmit model
  logic [31:0] m_ctrl = '0;
  logic [8:0]  m_hold = '0;
  int m_div = 0, m_sub = 0, m_n;
  bit m_busy = 0, m_hv = 0, m_tc = 1, m_tk, m_ld, m_fin, m_wrd, m_par;
  bit m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_div = 0; m_sub = 0; m_busy = 0; m_hv = 0; m_tc = 1; m_q.delete();
    end else begin
      m_n   = int'(m_ctrl[12:0]);
      m_tk  = (m_n != 0) && (m_div >= 2 * m_n - 1);
      m_wrd = wr_en && addr == 2'd2;
      m_ld  = !m_busy && m_hv && m_ctrl[13];
      m_fin = 0;
      if (m_n == 0 || m_tk) m_div = 0; else m_div++;
      if (m_ld) begin
        int w;
        w = m_ctrl[15] ? 9 : 8;
        m_par = m_ctrl[17];
        for (int i = 0; i < w - 1; i++) m_par ^= m_hold[i];
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < w; i++)
          m_q.push_back((m_ctrl[16] && i == w - 1) ? m_par : m_hold[i]);
        m_q.push_back(1'b1);
        m_busy = 1; m_sub = 0;
      end else if (m_busy && m_tk) begin
        if (m_sub == 15) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_busy = 0; m_fin = 1; end
        end
        m_sub = (m_sub + 1) % 16;
      end
      if (m_wrd) m_tc = 0; else if (m_fin && !m_hv) m_tc = 1;
      m_hv = m_wrd ? 1 : (m_ld ? 0 : m_hv);
      if (m_wrd) m_hold = wdata[8:0];
      if (wr_en && addr == 2'd0) m_ctrl = wdata;
    end
  end

  // per-cycle comparison, late in the low phase
  initial forever begin
    @(negedge clk); #3;
    check("R1 txd trace", {31'd0, txd}, {31'd0, m_busy ? m_q[0] : 1'b1});
    if (addr == 2'd1 && rst_n)
      check("R3 tdre/tc trace", {30'd0, rdata[1:0]}, {30'd0, m_tc, !m_hv});
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 2'd1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = 2'd1;
  endtask

  task automatic rd_take(output logic [31:0] d);
    @(negedge clk); addr = 2'd2; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; addr = 2'd1;
  endtask

  task automatic wait_tc();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      peek(2'd1, s);
      if (s[1]) break;
    end
    check("R3 transmit complete", {31'd0, s[1]}, 32'd1);
  endtask

  task automatic send(input logic [8:0] word, input int w, input logic stop, input int glitch);
    logic [10:0] f;
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < w; i++) f[i+1] = word[i];
    f[w+1] = stop;
    @(negedge clk);
    for (int i = 0; i < w + 2; i++) begin
      rxd = f[i];
      if (i == glitch) begin
        repeat (15) @(negedge clk); rxd = ~f[i];
        repeat (2) @(negedge clk); rxd = f[i];
        repeat (15) @(negedge clk);
      end else repeat (32) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s, d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    peek(2'd1, s); check("R3 reset status", s, 32'h03);
    peek(2'd0, s); check("R2 reset control", s, 32'h0);
    check("R1 reset txd", {31'd0, txd}, 32'd1);
    check("R12 reset irqs", {30'd0, irq_tx, irq_rx}, 32'd0);

    // R1 R3 R8: double-buffered 8-bit transmit, N=2
    wr(2'd0, 2 | TE | TXIE);
    check("R12 irq_tx on empty", {31'd0, irq_tx}, 32'd1);
    wr(2'd2, 32'hA5);
    wr(2'd2, 32'h3C);
    peek(2'd1, s); check("R3 holding full", {31'd0, s[0]}, 32'd0);
    check("R12 irq_tx off when full", {31'd0, irq_tx}, 32'd0);
    wait_tc();

    // R4 R5: 9-bit odd parity, and 8-bit even parity
    wr(2'd0, 1 | TE | NINE | PEN | PODD);
    wr(2'd2, 32'h1FF);
    wait_tc();
    wr(2'd0, 1 | TE | PEN);
    wr(2'd2, 32'h83);
    wait_tc();

    // R2: transmitter disabled holds the line
    wr(2'd0, 1);
    wr(2'd2, 32'h55);
    repeat (500) @(negedge clk);
    check("R2 te off txd idle", {31'd0, txd}, 32'd1);
    peek(2'd1, s); check("R2 te off no complete", {30'd0, s[1:0]}, 32'd0);
    wr(2'd0, 1 | TE);
    wait_tc();

    // R8: zero divisor stops timing
    wr(2'd0, TE);
    wr(2'd2, 32'h11);
    repeat (300) @(negedge clk);
    peek(2'd1, s); check("R8 no progress at N=0", {31'd0, s[1]}, 32'd0);
    wr(2'd0, 1 | TE);
    wait_tc();

    // receive tests, N=1
    wr(2'd0, 1 | RE | RXIE);
    send(9'h5A, 8, 1'b1, -1);
    peek(2'd1, s); check("R1 rx full, no errors", {24'd0, s[7:4], 1'b0, s[2], 2'b0}, 32'h04);
    check("R12 irq_rx set", {31'd0, irq_rx}, 32'd1);
    rd_take(d); check("R4 rx 8-bit data", d, 32'h5A);
    peek(2'd1, s); check("R12 read clears full", {31'd0, s[2]}, 32'd0);

    wr(2'd0, 1 | RE | NINE);
    send(9'h1C3, 9, 1'b1, -1);
    rd_take(d); check("R4 rx 9-bit data", d, 32'h1C3);

    wr(2'd0, 1 | RE | PEN);
    send(9'h03, 8, 1'b1, -1);
    peek(2'd1, s); check("R5 even parity ok", {31'd0, s[7]}, 32'd0);
    rd_take(d);
    send(9'h83, 8, 1'b1, -1);
    peek(2'd1, s); check("R5 even parity error", {31'd0, s[7]}, 32'd1);
    rd_take(d); check("R5 data kept with parity error", d, 32'h83);
    wr(2'd0, 1 | RE | NINE | PEN | PODD);
    send(9'h1FF, 9, 1'b1, -1);
    peek(2'd1, s); check("R5 odd parity ok", {31'd0, s[7]}, 32'd0);
    rd_take(d);

    wr(2'd0, 1 | RE);
    send(9'h5A, 8, 1'b1, 4);
    peek(2'd1, s); check("R6 noise flag", {29'd0, s[6], s[5], s[2]}, 32'b011);
    rd_take(d); check("R6 data despite glitch", d, 32'h5A);

    send(9'h3C, 8, 1'b0, -1);
    peek(2'd1, s); check("R11 framing error", {30'd0, s[6], s[2]}, 32'b11);
    rd_take(d); check("R11 data with framing error", d, 32'h3C);
    peek(2'd1, s); check("R12 read clears errors", {24'd0, s[7:4], 1'b0, s[2], 2'b0}, 32'h0);

    send(9'h11, 8, 1'b1, -1);
    send(9'h22, 8, 1'b1, -1);
    peek(2'd1, s); check("R10 overrun flag", {30'd0, s[4], s[2]}, 32'b11);
    rd_take(d); check("R10 first data kept", d, 32'h11);

    repeat (400) @(negedge clk);
    peek(2'd1, s); check("R9 idle line flag", {31'd0, s[3]}, 32'd1);
    rd_take(d);
    peek(2'd1, s); check("R9 idle cleared by read", {31'd0, s[3]}, 32'd0);

    // R7: wake on address mark
    wr(2'd0, 1 | RE | RXIE | WAKE | WADR);
    send(9'h12, 8, 1'b1, -1);
    peek(2'd1, s); check("R7 addr-wake discards", {31'd0, s[2]}, 32'd0);
    check("R7 no irq while asleep", {31'd0, irq_rx}, 32'd0);
    send(9'h93, 8, 1'b1, -1);
    peek(2'd1, s); check("R7 address char kept", {31'd0, s[2]}, 32'd1);
    peek(2'd0, s); check("R7 wake self-clears (addr)", {31'd0, s[18]}, 32'd0);
    rd_take(d); check("R7 address data", d, 32'h93);

    // R7: wake on idle line
    wr(2'd0, 1 | RE | WAKE);
    send(9'h44, 8, 1'b1, -1);
    peek(2'd1, s); check("R7 idle-wake discards", {31'd0, s[2]}, 32'd0);
    peek(2'd0, s); check("R7 still asleep", {31'd0, s[18]}, 32'd1);
    repeat (450) @(negedge clk);
    peek(2'd0, s); check("R7 wake self-clears (idle)", {31'd0, s[18]}, 32'd0);
    rd_take(d);
    send(9'h66, 8, 1'b1, -1);
    rd_take(d); check("R7 data after idle wake", d, 32'h66);

    // R2: receiver disabled
    wr(2'd0, 1);
    send(9'h77, 8, 1'b1, -1);
    peek(2'd1, s); check("R2 re off ignores line", {24'd0, s[7:4], 1'b0, s[2], 2'b0}, 32'h0);

    finish_run();
  end
endmodule